// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Victim Buffer

This block sits between a processor read port and a next-level memory. A byte address is split into a tag, a line index and a byte offset. Each memory block has exactly one home line in a direct-mapped array. A hit returns the stored 32-bit word. A miss fetches the block from the next level, installs it in its home line and returns it to the processor.

Valid lines that a fill pushes out of the direct-mapped array are not discarded. They go into a small fully associative victim buffer. On each lookup, every victim entry compares its stored block address in parallel. When the main array misses and the victim buffer hits, the two lines trade places and no next-level request is made. Two blocks that share a line index can then alternate without refetching. Only reads and line fills are handled, and at most one miss is in flight at a time.

Blocks are one 32-bit word (4 bytes), so the byte offset does not affect lookup or data. The address width, the index width and the victim depth are parameters. The default index is 8 bits, which keeps the default array small. A 14-bit index gives the 8-bit tag and 16K-line arrangement.

Top module: `vc_cache`

## Requirements
- R1: After reset every main line and every victim entry is invalid, so the first access to any address fetches from the next level. Out of reset, cpu_ready is 1, cpu_valid is 0 and mem_req is 0.
- R2: The block address is cpu_addr[ADDR_W-1:2], the line index is cpu_addr[IDX_W+1:2] and the tag is the bits above the index. Accesses whose addresses differ only in bits [1:0] read the same block.
- R3: A request accepted (cpu_req high while cpu_ready is 1) that hits in the main array returns the stored word with cpu_valid exactly one cycle after acceptance. No next-level request is made.
- R4: A request that misses both stores raises mem_req in the cycle after acceptance, with mem_addr equal to the block address. mem_req and mem_addr hold until mem_ready is 1. The word on mem_rdata in that cycle is installed and is returned on cpu_rdata with cpu_valid in the next cycle, three cycles after acceptance when the next level takes two cycles.
- R5: While a fill or a swap is in progress, cpu_ready is 0 and no request is accepted.
- R6: When a fill replaces a valid main line, that line is written into the victim buffer.
- R7: A request that misses the main array but hits the victim buffer returns the word with cpu_valid two cycles after acceptance, one cycle later than a main hit. It makes no next-level request, and the displaced main line takes the victim slot. After the first two fills, alternating two blocks that share an index never fetches again.
- R8: Victim insertions go to slots in cyclic order, so a full buffer overwrites the entry inserted longest ago. That block is then fetched again, while later entries still hit.
- R9: At most one victim entry matches any block address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Read request strobe |
| cpu_addr | input | ADDR_W | Byte address of the read |
| cpu_ready | output | 1 | High when a new request can be accepted |
| cpu_valid | output | 1 | One-cycle pulse with returned data |
| cpu_rdata | output | 32 | Returned word |
| mem_req | output | 1 | Block read request to the next level |
| mem_addr | output | ADDR_W-2 | Block address of the fill |
| mem_ready | input | 1 | Next level delivers the block this cycle |
| mem_rdata | input | 32 | Block data from the next level |

## Verification
A stimulus table first makes repeated reads of one block at different byte offsets, which separates offset handling from tag compare. It then alternates two blocks that share an index, where each access must be a swap and never a fetch; this tells the victim path apart from a plain direct-mapped refill. Six blocks are then streamed through one index to overflow the victim buffer. The oldest block must refetch while a newer one still swaps, which fixes the replacement order. Each access is classed by its latency (1, 2 or 3 cycles) together with the count of next-level reads, so a hit, a swap and a fill cannot be mistaken for one another. Directed cases cover the port state out of reset, the ready and request behaviour during a pending fill, and a second reset that must clear every stored line.

// File: rtl/vc_pkg.sv
package vc_pkg;

    localparam int WORD_W       = 32;
    localparam int OFF_W        = 2;
    localparam int DEF_ADDR_W   = 24;
    localparam int DEF_IDX_W    = 8;
    localparam int DEF_VICT_DEP = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SWAP  = 2'd1,
        ST_FETCH = 2'd2
    } vc_state_e;

endpackage

// File: rtl/vc_line_store.sv
module vc_line_store #(
    parameter int IDX_W  = 8,
    parameter int TAG_W  = 14,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];

endmodule

// File: rtl/vc_victim_store.sv
module vc_victim_store #(
    parameter int BLK_W  = 22,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [BLK_W-1:0]         lk_blk,
    output logic                     hit,
    output logic [DEPTH-1:0]         hit_vec,
    output logic [$clog2(DEPTH)-1:0] hit_slot,
    output logic [DATA_W-1:0]        hit_data,
    input  logic                     ins_en,
    input  logic [BLK_W-1:0]         ins_blk,
    input  logic [DATA_W-1:0]        ins_data,
    input  logic                     sw_en,
    input  logic [$clog2(DEPTH)-1:0] sw_slot,
    input  logic                     sw_keep,
    input  logic [BLK_W-1:0]         sw_blk,
    input  logic [DATA_W-1:0]        sw_data
);
    localparam int SLOT_W = $clog2(DEPTH);

    logic [DEPTH-1:0]  valid_q;
    logic [BLK_W-1:0]  blk_q  [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [SLOT_W-1:0] ptr_q;

    // parallel compare of every entry
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = valid_q[g] && (blk_q[g] == lk_blk);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_slot = '0;
        hit_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) begin
                hit_slot = SLOT_W'(i);
                hit_data = data_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else if (ins_en) begin
            valid_q[ptr_q] <= 1'b1;
            ptr_q          <= (ptr_q == SLOT_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
        end else if (sw_en) begin
            valid_q[sw_slot] <= sw_keep;
        end
    end

    always_ff @(posedge clk) begin
        if (ins_en) begin
            blk_q[ptr_q]  <= ins_blk;
            data_q[ptr_q] <= ins_data;
        end else if (sw_en) begin
            blk_q[sw_slot]  <= sw_blk;
            data_q[sw_slot] <= sw_data;
        end
    end

endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
    import vc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 8,
    parameter int DEPTH  = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cpu_req,
    input  logic [ADDR_W-1:0]             cpu_addr,
    output logic                          cpu_ready,
    output logic                          cpu_valid,
    output logic [WORD_W-1:0]             cpu_rdata,
    output logic                          mem_req,
    output logic [ADDR_W-OFF_W-1:0]       mem_addr,
    input  logic                          mem_ready,
    input  logic [WORD_W-1:0]             mem_rdata,
    output logic [IDX_W-1:0]              look_idx,
    input  logic                          main_valid,
    input  logic [ADDR_W-IDX_W-OFF_W-1:0] main_tag,
    input  logic [WORD_W-1:0]             main_data,
    output logic                          main_wr_en,
    output logic [IDX_W-1:0]              main_wr_idx,
    output logic [ADDR_W-IDX_W-OFF_W-1:0] main_wr_tag,
    output logic [WORD_W-1:0]             main_wr_data,
    output logic [ADDR_W-OFF_W-1:0]       vic_lk_blk,
    input  logic                          vic_hit,
    input  logic [$clog2(DEPTH)-1:0]      vic_slot,
    input  logic [WORD_W-1:0]             vic_data,
    output logic                          vic_ins_en,
    output logic [ADDR_W-OFF_W-1:0]       vic_ins_blk,
    output logic [WORD_W-1:0]             vic_ins_data,
    output logic                          vic_sw_en,
    output logic [$clog2(DEPTH)-1:0]      vic_sw_slot,
    output logic                          vic_sw_keep,
    output logic [ADDR_W-OFF_W-1:0]       vic_sw_blk,
    output logic [WORD_W-1:0]             vic_sw_data
);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int SLOT_W = $clog2(DEPTH);

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
    } blk_t;

    vc_state_e   state_q, state_d;
    blk_t        req_q, req_d, in_blk;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic [WORD_W-1:0] vdata_q, vdata_d;
    logic              out_vld_q, out_vld_d;
    logic [WORD_W-1:0] out_dat_q, out_dat_d;
    logic              main_hit;
    logic              unused_off;

    assign in_blk     = blk_t'(cpu_addr[ADDR_W-1:OFF_W]);
    assign unused_off = ^cpu_addr[OFF_W-1:0];
    assign look_idx   = (state_q == ST_IDLE) ? in_blk.idx : req_q.idx;
    assign vic_lk_blk = in_blk;
    assign main_hit   = main_valid && (main_tag == in_blk.tag);

    assign cpu_ready = (state_q == ST_IDLE);
    assign mem_req   = (state_q == ST_FETCH);
    assign mem_addr  = req_q;
    assign cpu_valid = out_vld_q;
    assign cpu_rdata = out_dat_q;

    always_comb begin
        state_d   = state_q;
        req_d     = req_q;
        slot_d    = slot_q;
        vdata_d   = vdata_q;
        out_vld_d = 1'b0;
        out_dat_d = out_dat_q;

        main_wr_en   = 1'b0;
        main_wr_idx  = req_q.idx;
        main_wr_tag  = req_q.tag;
        main_wr_data = mem_rdata;

        vic_ins_en   = 1'b0;
        vic_ins_blk  = {main_tag, req_q.idx};
        vic_ins_data = main_data;
        vic_sw_en    = 1'b0;
        vic_sw_slot  = slot_q;
        vic_sw_keep  = main_valid;
        vic_sw_blk   = {main_tag, req_q.idx};
        vic_sw_data  = main_data;

        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (main_hit) begin
                        out_vld_d = 1'b1;
                        out_dat_d = main_data;
                    end else if (vic_hit) begin
                        req_d   = in_blk;
                        slot_d  = vic_slot;
                        vdata_d = vic_data;
                        state_d = ST_SWAP;
                    end else begin
                        req_d   = in_blk;
                        state_d = ST_FETCH;
                    end
                end
            end
            ST_SWAP: begin
                // victim line moves home, home line takes the victim slot
                main_wr_en   = 1'b1;
                main_wr_data = vdata_q;
                vic_sw_en    = 1'b1;
                out_vld_d    = 1'b1;
                out_dat_d    = vdata_q;
                state_d      = ST_IDLE;
            end
            ST_FETCH: begin
                if (mem_ready) begin
                    main_wr_en = 1'b1;
                    vic_ins_en = main_valid;
                    out_vld_d  = 1'b1;
                    out_dat_d  = mem_rdata;
                    state_d    = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            out_vld_q <= 1'b0;
            out_dat_q <= '0;
            req_q     <= '0;
            slot_q    <= '0;
            vdata_q   <= '0;
        end else begin
            state_q   <= state_d;
            out_vld_q <= out_vld_d;
            out_dat_q <= out_dat_d;
            req_q     <= req_d;
            slot_q    <= slot_d;
            vdata_q   <= vdata_d;
        end
    end

endmodule

// File: rtl/vc_cache.sv
module vc_cache
    import vc_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int IDX_W      = DEF_IDX_W,
    parameter int VICT_DEPTH = DEF_VICT_DEP
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cpu_req,
    input  logic [ADDR_W-1:0]       cpu_addr,
    output logic                    cpu_ready,
    output logic                    cpu_valid,
    output logic [WORD_W-1:0]       cpu_rdata,
    output logic                    mem_req,
    output logic [ADDR_W-OFF_W-1:0] mem_addr,
    input  logic                    mem_ready,
    input  logic [WORD_W-1:0]       mem_rdata
);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int BLK_W  = ADDR_W - OFF_W;
    localparam int SLOT_W = $clog2(VICT_DEPTH);

    logic [IDX_W-1:0]  look_idx;
    logic              main_valid;
    logic [TAG_W-1:0]  main_tag;
    logic [WORD_W-1:0] main_data;
    logic              main_wr_en;
    logic [IDX_W-1:0]  main_wr_idx;
    logic [TAG_W-1:0]  main_wr_tag;
    logic [WORD_W-1:0] main_wr_data;

    logic [BLK_W-1:0]      vic_lk_blk;
    logic                  vic_hit;
    logic [VICT_DEPTH-1:0] vic_hit_vec;
    logic [SLOT_W-1:0]     vic_slot;
    logic [WORD_W-1:0]     vic_data;
    logic                  vic_ins_en;
    logic [BLK_W-1:0]      vic_ins_blk;
    logic [WORD_W-1:0]     vic_ins_data;
    logic                  vic_sw_en;
    logic [SLOT_W-1:0]     vic_sw_slot;
    logic                  vic_sw_keep;
    logic [BLK_W-1:0]      vic_sw_blk;
    logic [WORD_W-1:0]     vic_sw_data;

    vc_line_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .DATA_W(WORD_W)
    ) u_main (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (look_idx),
        .rd_valid(main_valid),
        .rd_tag  (main_tag),
        .rd_data (main_data),
        .wr_en   (main_wr_en),
        .wr_idx  (main_wr_idx),
        .wr_tag  (main_wr_tag),
        .wr_data (main_wr_data)
    );

    vc_victim_store #(
        .BLK_W (BLK_W),
        .DATA_W(WORD_W),
        .DEPTH (VICT_DEPTH)
    ) u_vict (
        .clk     (clk),
        .rst     (rst),
        .lk_blk  (vic_lk_blk),
        .hit     (vic_hit),
        .hit_vec (vic_hit_vec),
        .hit_slot(vic_slot),
        .hit_data(vic_data),
        .ins_en  (vic_ins_en),
        .ins_blk (vic_ins_blk),
        .ins_data(vic_ins_data),
        .sw_en   (vic_sw_en),
        .sw_slot (vic_sw_slot),
        .sw_keep (vic_sw_keep),
        .sw_blk  (vic_sw_blk),
        .sw_data (vic_sw_data)
    );

    vc_ctrl #(
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W),
        .DEPTH (VICT_DEPTH)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cpu_req     (cpu_req),
        .cpu_addr    (cpu_addr),
        .cpu_ready   (cpu_ready),
        .cpu_valid   (cpu_valid),
        .cpu_rdata   (cpu_rdata),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_ready   (mem_ready),
        .mem_rdata   (mem_rdata),
        .look_idx    (look_idx),
        .main_valid  (main_valid),
        .main_tag    (main_tag),
        .main_data   (main_data),
        .main_wr_en  (main_wr_en),
        .main_wr_idx (main_wr_idx),
        .main_wr_tag (main_wr_tag),
        .main_wr_data(main_wr_data),
        .vic_lk_blk  (vic_lk_blk),
        .vic_hit     (vic_hit),
        .vic_slot    (vic_slot),
        .vic_data    (vic_data),
        .vic_ins_en  (vic_ins_en),
        .vic_ins_blk (vic_ins_blk),
        .vic_ins_data(vic_ins_data),
        .vic_sw_en   (vic_sw_en),
        .vic_sw_slot (vic_sw_slot),
        .vic_sw_keep (vic_sw_keep),
        .vic_sw_blk  (vic_sw_blk),
        .vic_sw_data (vic_sw_data)
    );

endmodule

// File: rtl/vc_cache_chk.sv
module vc_cache_chk #(
    parameter int BLK_W = 22,
    parameter int DEPTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_req,
    input logic             cpu_ready,
    input logic             cpu_valid,
    input logic             mem_req,
    input logic             mem_ready,
    input logic [BLK_W-1:0] mem_addr,
    input logic [DEPTH-1:0] vic_hit_vec
);

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cpu_ready && !cpu_valid && !mem_req));

    assert_fill_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    assert_fill_return_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready) |=> (cpu_valid && !mem_req));

    assert_busy_not_ready_R5: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !cpu_ready);

    assert_swap_no_fetch_R7: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_ready && (|vic_hit_vec)) |=> !mem_req);

    assert_swap_latency_R7: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_ready && (|vic_hit_vec)) |=> ##1 cpu_valid);

    assert_unique_victim_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(vic_hit_vec));

endmodule

bind vc_cache vc_cache_chk #(
    .BLK_W(ADDR_W - vc_pkg::OFF_W),
    .DEPTH(VICT_DEPTH)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_req    (cpu_req),
    .cpu_ready  (cpu_ready),
    .cpu_valid  (cpu_valid),
    .mem_req    (mem_req),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .vic_hit_vec(vic_hit_vec)
);

// File: tb/vc_cache_tb.sv
`timescale 1ns/1ps
module vc_cache_tb;

    localparam int N_VEC = 20;
    // {kind, addr}: kind 0 = main hit, 1 = victim swap, 2 = next-level fill
    localparam logic [25:0] VEC [N_VEC] = '{
        {2'd2, 24'h000100},  // A fill           R4
        {2'd0, 24'h000101},  // A other offset   R2
        {2'd0, 24'h000103},  // A hit            R3
        {2'd2, 24'h000500},  // B fill, A out    R6
        {2'd1, 24'h000100},  // A swap           R7
        {2'd1, 24'h000502},  // B swap           R7
        {2'd1, 24'h000100},
        {2'd1, 24'h000500},
        {2'd0, 24'h000500},  // B home hit       R3
        {2'd2, 24'h000104},  // C0..C5 same index
        {2'd2, 24'h000504},
        {2'd2, 24'h000904},
        {2'd2, 24'h000D04},
        {2'd2, 24'h001104},
        {2'd2, 24'h001504},
        {2'd2, 24'h000104},  // C0 overwritten   R8
        {2'd1, 24'h000904},  // C2 still held    R8
        {2'd2, 24'h000100},  // A overwritten    R8
        {2'd2, 24'hFFF100},  // high tag fill    R2
        {2'd1, 24'h000100}   // A swap back      R7
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic        cpu_ready;
    logic        cpu_valid;
    logic [31:0] cpu_rdata;
    logic        mem_req;
    logic [21:0] mem_addr;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int fetches = 0;

    always #5 clk = ~clk;

    vc_cache u_dut (
        .clk      (clk),
        .rst      (rst),
        .cpu_req  (cpu_req),
        .cpu_addr (cpu_addr),
        .cpu_ready(cpu_ready),
        .cpu_valid(cpu_valid),
        .cpu_rdata(cpu_rdata),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .mem_ready(mem_ready),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] blk_word(input logic [21:0] b);
        return {b, 10'h000} ^ 32'h5A5A_3C3C;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // next-level model: answers two cycles after mem_req is first seen
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_ready) begin
                mem_ready = 1'b0;
                cnt = 0;
            end else if (mem_req && !rst) begin
                cnt++;
                if (cnt == 2) begin
                    mem_ready = 1'b1;
                    mem_rdata = blk_word(mem_addr);
                    fetches++;
                end
            end else begin
                cnt = 0;
            end
        end
    end

    task automatic access(input logic [23:0] a, input int kind, input string req);
        int lat = 0;
        bit got = 0;
        int f0;
        int exp_lat;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        f0 = fetches;
        cpu_req  = 1'b1;
        cpu_addr = a;
        @(negedge clk);
        cpu_req = 1'b0;
        lat = 1;
        if (cpu_valid) got = 1;
        while (!got && lat < 20) begin
            @(negedge clk);
            lat++;
            if (cpu_valid) got = 1;
        end
        exp_lat = kind + 1;
        chk(lat == exp_lat, {req, " latency"}, 32'(lat), 32'(exp_lat));
        chk(cpu_rdata == blk_word(a[23:2]), {req, " data"}, cpu_rdata, blk_word(a[23:2]));
        chk((fetches - f0) == (kind == 2 ? 1 : 0), {req, " fetch count"},
            32'(fetches - f0), (kind == 2) ? 32'd1 : 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cpu_ready == 1'b1, "R1 ready out of reset", 32'(cpu_ready), 32'd1);
        chk(cpu_valid == 1'b0, "R1 valid out of reset", 32'(cpu_valid), 32'd0);
        chk(mem_req == 1'b0, "R1 mem_req out of reset", 32'(mem_req), 32'd0);

        for (int i = 0; i < N_VEC; i++) begin
            string tag;
            case (int'(VEC[i][25:24]))
                0:       tag = $sformatf("R3 vec%0d", i);
                1:       tag = $sformatf("R7 vec%0d", i);
                default: tag = $sformatf("R4 vec%0d", i);
            endcase
            access(VEC[i][23:0], int'(VEC[i][25:24]), tag);
        end

        // R5: request and ready during a pending fill
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_req  = 1'b1;
        cpu_addr = 24'h000108;
        @(negedge clk);
        cpu_req = 1'b0;
        chk(mem_req == 1'b1, "R4 mem_req raised", 32'(mem_req), 32'd1);
        chk(mem_addr == 22'h000042, "R4 block address", 32'(mem_addr), 32'h42);
        chk(cpu_ready == 1'b0, "R5 ready low while pending", 32'(cpu_ready), 32'd0);
        @(negedge clk);
        chk(cpu_ready == 1'b0, "R5 ready still low", 32'(cpu_ready), 32'd0);
        @(negedge clk);
        chk(cpu_valid == 1'b1, "R4 fill returned", 32'(cpu_valid), 32'd1);
        chk(cpu_rdata == blk_word(22'h42), "R4 fill data", cpu_rdata, blk_word(22'h42));

        // R1: second reset invalidates stored lines
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        access(24'h000100, 2, "R1 refetch after reset");
        access(24'h000108, 2, "R1 refetch second line");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule